// File: doc/BRIEF.md
# SMO Working-Pair Selector

This block picks the pair of training samples that the next step of Sequential Minimal Optimization will optimize. It makes one ascending pass over the stored samples. For each sample it reads the multiplier, the one-bit label and the error term through a synchronous read port. It then sorts the sample into an upper candidate set, a lower candidate set, or both. Along the way it keeps the largest error seen in the upper set and the smallest error seen in the lower set, each with the index where it was found.

When the pass ends, the block reports both indices and both error values. In the same pass it also decides whether training has converged: the gap between the two extreme errors is compared with a tolerance. The sample count, the box constant and the tolerance are sampled when a pass starts. All values are 24-bit signed fixed point with 18 fractional bits.

The sample data arrives over a fixed-latency memory read: an address goes out with `rd_en`, and the data is expected in the following cycle. This port has no back-pressure. Control is a plain start/busy/done handshake.

Top module: `smo_wss`

## Requirements
- R1: A sample is in the upper set when (alpha < C and label bit = 1) or (alpha > 0 and label bit = 0). Label bit 1 means y = +1 and label bit 0 means y = -1, and every comparison is signed.
- R2: A sample is in the lower set when (alpha < C and label bit = 0) or (alpha > 0 and label bit = 1). A sample with 0 < alpha < C belongs to both sets, and a sample with alpha = C belongs to only one set.
- R3: `up_idx`/`b_up` report the upper-set sample with the largest error value. `low_idx`/`b_low` report the lower-set sample with the smallest error value.
- R4: When several samples tie for an extreme value, the lowest sample index is reported.
- R5: `converged` is 1 when b_up - b_low < tol. The difference is formed one bit wider than the data, so extreme operands never wrap, and the comparison is strict.
- R6: When a set is empty, its index and its value are reported as 0 and `converged` is 1.
- R7: During a pass, `rd_en` is high for exactly m consecutive cycles, starting the cycle after start is taken. `rd_addr` steps 0, 1, ..., m-1. Read data is taken one cycle after each address.
- R8: `done` is a one-cycle pulse that rises m+2 clock edges after the edge that accepted `start`. `busy` is high from that accepting edge until `done` rises.
- R9: `start` is ignored while `busy` is high. The result outputs only change on the edge that raises `done`, so they hold through idle time and through the next pass.
- R10: With m = 0, a pass reads nothing and finishes after 2 edges with `converged` = 1 and all indices and values equal to 0.
- R11: After reset, `busy`, `done`, `rd_en`, `converged` and all indices and values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| num_samples | input | clog2(MAX_SAMPLES)+1 | Sample count m, sampled at start |
| box_c | input | W | Box constant C, signed, sampled at start |
| tol | input | W | Stopping tolerance, signed, sampled at start |
| rd_en | output | 1 | Read request to the sample memories |
| rd_addr | output | clog2(MAX_SAMPLES) | Sample index being read |
| rd_alpha | input | W | Multiplier of the addressed sample, one cycle later |
| rd_label | input | 1 | Label bit of the addressed sample (1 = +1) |
| rd_err | input | W | Error term of the addressed sample |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| up_idx | output | clog2(MAX_SAMPLES) | Index of the chosen upper sample |
| low_idx | output | clog2(MAX_SAMPLES) | Index of the chosen lower sample |
| b_up | output | W | Largest error in the upper set |
| b_low | output | W | Smallest error in the lower set |
| converged | output | 1 | Stopping test result |

## Verification
The bench places samples with alpha exactly equal to C next to extreme error values. A design that tests alpha <= C, or that swaps the label sense, would then pick a sample that is not eligible, and the reported index would be wrong. Repeated extreme values show whether a design keeps the lowest index or drifts to the last tie. Other tests cover:
- both empty-set cases;
- a zero-sample pass;
- operands at the two ends of the signed range, which would make a same-width subtraction wrap and report convergence falsely;
- a tolerance exactly equal to the gap, which separates a strict comparison from a non-strict one.

A start pulse in the middle of a scan, and checks on the outputs while idle and during a later pass, catch a design that restarts or lets its outputs follow the running trackers.

// File: rtl/smo_wss_pkg.sv
`timescale 1ns/1ps
package smo_wss_pkg;

  // Set membership of one sample.
  typedef struct packed {
    logic in_up;
    logic in_low;
  } member_t;

  // Direction of an extreme-value tracker.
  typedef enum logic {
    TRACK_MAX = 1'b0,
    TRACK_MIN = 1'b1
  } track_dir_e;

endpackage

// File: rtl/smo_wss_classify.sv
`timescale 1ns/1ps
module smo_wss_classify
  import smo_wss_pkg::*;
#(
  parameter int W = 24
) (
  input  logic signed [W-1:0] alpha,
  input  logic signed [W-1:0] box_c,
  input  logic                label_pos,
  output member_t             member
);

  localparam logic signed [W-1:0] ZERO = '0;

  logic below_c;
  logic above_zero;

  always_comb begin
    below_c       = alpha < box_c;
    above_zero    = alpha > ZERO;
    member.in_up  = (below_c && label_pos) || (above_zero && !label_pos);
    member.in_low = (below_c && !label_pos) || (above_zero && label_pos);
  end

  // R2: a sample strictly inside the box is a candidate for both sets
  always_comb begin
    if (above_zero && below_c) begin
      assert (member.in_up && member.in_low)
        else $error("p_inner_both_r2");
    end
  end

endmodule

// File: rtl/smo_wss_addr_gen.sv
`timescale 1ns/1ps
module smo_wss_addr_gen #(
  parameter int IDX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [IDX_W:0]     count,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_addr,
  output logic               last
);

  localparam int CNT_W = IDX_W + 1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (launch) begin
      run_q <= (count != '0);
      cnt_q <= '0;
      lim_q <= count;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) run_q <= 1'b0;
    end
  end

  assign rd_en   = run_q;
  assign rd_addr = cnt_q[IDX_W-1:0];
  assign last    = run_q && (cnt_q == lim_q - 1'b1);

  // R7: reads never go past the sample count
  p_addr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cnt_q < lim_q));

  // R7: addresses advance by one on consecutive cycles until the last one
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !last && !launch) |=> (rd_en && (rd_addr == $past(rd_addr) + 1'b1)));

endmodule

// File: rtl/smo_wss_tracker.sv
`timescale 1ns/1ps
module smo_wss_tracker
  import smo_wss_pkg::*;
#(
  parameter int         W     = 24,
  parameter int         IDX_W = 10,
  parameter track_dir_e DIR   = TRACK_MAX
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] val,
  input  logic [IDX_W-1:0]    idx,
  output logic                found,
  output logic signed [W-1:0] best_val,
  output logic [IDX_W-1:0]    best_idx
);

  logic wins;

  generate
    if (DIR == TRACK_MAX) begin : g_max
      assign wins = val > best_val;
    end else begin : g_min
      assign wins = val < best_val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found    <= 1'b0;
      best_val <= '0;
      best_idx <= '0;
    end else if (clr) begin
      found    <= 1'b0;
      best_val <= '0;
      best_idx <= '0;
    end else if (upd && (!found || wins)) begin
      found    <= 1'b1;
      best_val <= val;
      best_idx <= idx;
    end
  end

  // R3: once a candidate is held, it is kept until the next pass clears it
  p_found_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !clr) |=> found);

  // R4: an equal value never displaces the earlier (lower) index
  p_tie_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && found && !clr && (val == best_val)) |=> (best_idx == $past(best_idx)));

endmodule

// File: rtl/smo_wss.sv
`timescale 1ns/1ps
module smo_wss
  import smo_wss_pkg::*;
#(
  parameter int W           = 24,
  parameter int MAX_SAMPLES = 1024
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [$clog2(MAX_SAMPLES):0]     num_samples,
  input  logic signed [W-1:0]              box_c,
  input  logic signed [W-1:0]              tol,
  output logic                             rd_en,
  output logic [$clog2(MAX_SAMPLES)-1:0]   rd_addr,
  input  logic signed [W-1:0]              rd_alpha,
  input  logic                             rd_label,
  input  logic signed [W-1:0]              rd_err,
  output logic                             busy,
  output logic                             done,
  output logic [$clog2(MAX_SAMPLES)-1:0]   up_idx,
  output logic [$clog2(MAX_SAMPLES)-1:0]   low_idx,
  output logic signed [W-1:0]              b_up,
  output logic signed [W-1:0]              b_low,
  output logic                             converged
);

  localparam int IDX_W = $clog2(MAX_SAMPLES);
  localparam int DW    = W + 1;

  // ---------------- control ----------------
  logic                accept;
  logic                issue_last;
  logic                v1_q;
  logic [IDX_W-1:0]    idx1_q;
  logic                last1_q;
  logic                fin_q;
  logic signed [W-1:0] box_q;
  logic signed [W-1:0] tol_q;

  assign accept = start && !busy;

  smo_wss_addr_gen #(.IDX_W(IDX_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (accept),
    .count   (num_samples),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .last    (issue_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      v1_q    <= 1'b0;
      idx1_q  <= '0;
      last1_q <= 1'b0;
      fin_q   <= 1'b0;
      box_q   <= '0;
      tol_q   <= '0;
    end else begin
      v1_q    <= rd_en;
      idx1_q  <= rd_addr;
      last1_q <= issue_last || (accept && (num_samples == '0));
      fin_q   <= last1_q;
      if (accept) begin
        busy  <= 1'b1;
        box_q <= box_c;
        tol_q <= tol;
      end else if (fin_q) begin
        busy  <= 1'b0;
      end
    end
  end

  // ---------------- classification ----------------
  member_t member;

  smo_wss_classify #(.W(W)) u_cls (
    .alpha     (rd_alpha),
    .box_c     (box_q),
    .label_pos (rd_label),
    .member    (member)
  );

  // ---------------- extreme trackers ----------------
  logic                up_found;
  logic signed [W-1:0] up_val;
  logic [IDX_W-1:0]    up_best_idx;
  logic                low_found;
  logic signed [W-1:0] low_val;
  logic [IDX_W-1:0]    low_best_idx;

  smo_wss_tracker #(.W(W), .IDX_W(IDX_W), .DIR(TRACK_MAX)) u_up (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .upd      (v1_q && member.in_up),
    .val      (rd_err),
    .idx      (idx1_q),
    .found    (up_found),
    .best_val (up_val),
    .best_idx (up_best_idx)
  );

  smo_wss_tracker #(.W(W), .IDX_W(IDX_W), .DIR(TRACK_MIN)) u_low (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .upd      (v1_q && member.in_low),
    .val      (rd_err),
    .idx      (idx1_q),
    .found    (low_found),
    .best_val (low_val),
    .best_idx (low_best_idx)
  );

  // ---------------- stopping test ----------------
  logic signed [DW-1:0] gap;
  logic signed [DW-1:0] tol_x;
  logic                 conv_next;

  always_comb begin
    gap       = {up_val[W-1], up_val} - {low_val[W-1], low_val};
    tol_x     = {tol_q[W-1], tol_q};
    conv_next = !up_found || !low_found || (gap < tol_x);
  end

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      up_idx    <= '0;
      low_idx   <= '0;
      b_up      <= '0;
      b_low     <= '0;
      converged <= 1'b0;
    end else begin
      done <= fin_q;
      if (fin_q) begin
        up_idx    <= up_best_idx;
        low_idx   <= low_best_idx;
        b_up      <= up_val;
        b_low     <= low_val;
        converged <= conv_next;
      end
    end
  end

  // R8: done lasts exactly one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done rises only as busy drops
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a pass runs to its end regardless of further start pulses
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_q) |=> busy);

  // R9: results hold while idle
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(up_idx) && $stable(low_idx) && $stable(b_up)
               && $stable(b_low) && $stable(converged)));

  // R6: an empty set forces convergence and a zero report
  p_empty_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && !up_found) |=> (converged && (b_up == '0) && (up_idx == '0)));

  // R7: no reads while idle
  p_no_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

endmodule

// File: tb/smo_wss_tb.sv
`timescale 1ns/1ps
module smo_wss_tb;

  localparam int W    = 24;
  localparam int MAXS = 64;
  localparam int IW   = 6;
  localparam int ONE  = 262144;
  localparam int HALF = 131072;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n;
  logic                start;
  logic [IW:0]         num_samples;
  logic signed [W-1:0] box_c;
  logic signed [W-1:0] tol;
  logic                rd_en;
  logic [IW-1:0]       rd_addr;
  logic signed [W-1:0] rd_alpha;
  logic                rd_label;
  logic signed [W-1:0] rd_err;
  logic                busy;
  logic                done;
  logic [IW-1:0]       up_idx;
  logic [IW-1:0]       low_idx;
  logic signed [W-1:0] b_up;
  logic signed [W-1:0] b_low;
  logic                converged;

  smo_wss #(.W(W), .MAX_SAMPLES(MAXS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_samples(num_samples),
    .box_c(box_c), .tol(tol), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_alpha(rd_alpha), .rd_label(rd_label), .rd_err(rd_err),
    .busy(busy), .done(done), .up_idx(up_idx), .low_idx(low_idx),
    .b_up(b_up), .b_low(b_low), .converged(converged)
  );

  // sample memories with one cycle of read latency
  logic signed [W-1:0] a_mem [MAXS];
  logic                l_mem [MAXS];
  logic signed [W-1:0] f_mem [MAXS];

  always @(posedge clk) begin
    if (rd_en) begin
      rd_alpha <= a_mem[rd_addr];
      rd_label <= l_mem[rd_addr];
      rd_err   <= f_mem[rd_addr];
    end
  end

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL R8 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_s(input int i, input int a, input bit l, input int f);
    a_mem[i] = W'(a);
    l_mem[i] = l;
    f_mem[i] = W'(f);
  endtask

  // reference expectations
  int r_up_idx, r_low_idx, r_up_val, r_low_val;
  bit r_conv;

  task automatic ref_model(input int m);
    bit uf = 0;
    bit lf = 0;
    int bu = 0;
    int bl = 0;
    int iu = 0;
    int il = 0;
    for (int i = 0; i < m; i++) begin
      int a = int'(a_mem[i]);
      int f = int'(f_mem[i]);
      bit up  = ((a < int'(box_c)) && l_mem[i]) || ((a > 0) && !l_mem[i]);
      bit low = ((a < int'(box_c)) && !l_mem[i]) || ((a > 0) && l_mem[i]);
      if (up && (!uf || f > bu)) begin uf = 1; bu = f; iu = i; end
      if (low && (!lf || f < bl)) begin lf = 1; bl = f; il = i; end
    end
    r_up_idx  = iu;
    r_low_idx = il;
    r_up_val  = bu;
    r_low_val = bl;
    r_conv    = !uf || !lf || ((longint'(bu) - longint'(bl)) < longint'(int'(tol)));
  endtask

  task automatic check_out(input string req, input string conv_req);
    chk(req, "up_idx", up_idx, r_up_idx);
    chk(req, "low_idx", low_idx, r_low_idx);
    chk(req, "b_up", b_up, r_up_val);
    chk(req, "b_low", b_low, r_low_val);
    chk(conv_req, "converged", converged, r_conv);
  endtask

  // saved outputs for hold checks
  int sv_up, sv_low, sv_bu, sv_bl;
  bit sv_conv;

  task automatic save_out();
    sv_up = up_idx; sv_low = low_idx; sv_bu = b_up; sv_bl = b_low; sv_conv = converged;
  endtask

  // one pass; called and returning at a negedge
  task automatic run_pass(input int m, input bit extra_start, input bit hold_chk);
    int n = 0;
    int exp_addr = 0;
    bit addr_bad = 0;
    bit busy_bad = 0;
    int extra_done = 0;
    num_samples = (IW+1)'(m);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && n < m + 20) begin
      if (!busy) busy_bad = 1;
      if (rd_en) begin
        if (int'(rd_addr) != exp_addr) addr_bad = 1;
        exp_addr++;
      end
      if (hold_chk && n == 3) begin
        chk("R9", "up_idx held during pass", up_idx, sv_up);
        chk("R9", "b_low held during pass", b_low, sv_bl);
        chk("R9", "converged held during pass", converged, sv_conv);
      end
      start = (extra_start && n == 2);
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(m == 0 ? "R10" : "R8", "done latency", n, m + 2);
    chk("R8", "busy through pass", busy_bad, 0);
    chk("R7", "address order", addr_bad, 0);
    chk("R7", "read count", exp_addr, m);
    chk("R8", "busy low at done", busy, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8", "done pulse width", done, 0);
    if (extra_start) begin
      for (int k = 0; k < m + 6; k++) begin
        if (done || busy) extra_done++;
        @(posedge clk);
        @(negedge clk);
      end
      chk("R9", "start while busy ignored", extra_done, 0);
    end
  endtask

  task automatic t_reset();
    chk("R11", "busy", busy, 0);
    chk("R11", "done", done, 0);
    chk("R11", "rd_en", rd_en, 0);
    chk("R11", "converged", converged, 0);
    chk("R11", "up_idx", up_idx, 0);
    chk("R11", "b_low", b_low, 0);
  endtask

  // alpha == C traps and mixed membership
  task automatic t_hand();
    box_c = ONE; tol = 262;
    set_s(0, 0,    1, 1000);
    set_s(1, ONE,  1, 9000);
    set_s(2, HALF, 0, 2500);
    set_s(3, ONE,  0, -9000);
    set_s(4, 0,    0, -3000);
    set_s(5, HALF, 1, -100);
    run_pass(6, 0, 0);
    chk("R1", "up_idx hand", up_idx, 2);
    chk("R1", "b_up hand", b_up, 2500);
    chk("R2", "low_idx hand", low_idx, 4);
    chk("R2", "b_low hand", b_low, -3000);
    chk("R5", "converged hand", converged, 0);
  endtask

  task automatic t_pattern();
    box_c = ONE; tol = 262;
    for (int i = 0; i < 40; i++) begin
      int a = (i % 3 == 0) ? 0 : ((i % 3 == 1) ? HALF : ONE);
      set_s(i, a, ((i * 5) % 7) > 2, (((i * 37) % 29) - 14) * 4096);
    end
    ref_model(40);
    run_pass(40, 1, 0);
    check_out("R3", "R5");
  endtask

  task automatic t_ties();
    box_c = ONE; tol = 0;
    set_s(0, HALF, 1, 10);
    set_s(1, HALF, 0, 70);
    set_s(2, HALF, 1, -40);
    set_s(3, HALF, 0, 10);
    set_s(4, HALF, 1, 70);
    set_s(5, HALF, 0, -40);
    run_pass(6, 0, 0);
    chk("R4", "tie up_idx", up_idx, 1);
    chk("R4", "tie low_idx", low_idx, 2);
    chk("R5", "converged ties", converged, 0);
  endtask

  task automatic t_empty();
    box_c = ONE; tol = 262;
    set_s(0, 0, 0, 5);
    set_s(1, 0, 0, -7);
    set_s(2, 0, 0, 3);
    set_s(3, 0, 0, -7);
    run_pass(4, 0, 0);
    chk("R6", "empty up idx", up_idx, 0);
    chk("R6", "empty up val", b_up, 0);
    chk("R6", "empty up low_idx", low_idx, 1);
    chk("R6", "empty up converged", converged, 1);
    set_s(0, 0, 1, 5);
    set_s(1, 0, 1, 9);
    set_s(2, 0, 1, 9);
    set_s(3, 0, 1, 1);
    run_pass(4, 0, 0);
    chk("R6", "empty low up_idx", up_idx, 1);
    chk("R6", "empty low idx", low_idx, 0);
    chk("R6", "empty low val", b_low, 0);
    chk("R6", "empty low converged", converged, 1);
  endtask

  task automatic t_overflow();
    box_c = ONE; tol = 262;
    set_s(0, 0, 1, 32'h007F_FFFF);
    set_s(1, 0, 0, -8388608);
    run_pass(2, 0, 0);
    chk("R5", "wide gap b_up", b_up, 8388607);
    chk("R5", "wide gap b_low", b_low, -8388608);
    chk("R5", "wide gap converged", converged, 0);
  endtask

  task automatic t_zero();
    box_c = ONE; tol = 262;
    run_pass(0, 0, 0);
    chk("R10", "zero converged", converged, 1);
    chk("R10", "zero up_idx", up_idx, 0);
    chk("R10", "zero b_up", b_up, 0);
    chk("R10", "zero b_low", b_low, 0);
  endtask

  task automatic t_tol_edge();
    box_c = ONE;
    set_s(0, 0, 1, 100);
    set_s(1, 0, 0, 50);
    tol = 51;
    run_pass(2, 0, 0);
    chk("R5", "gap below tol", converged, 1);
    tol = 50;
    run_pass(2, 0, 0);
    chk("R5", "gap equal tol", converged, 0);
  endtask

  task automatic t_hold();
    save_out();
    for (int k = 0; k < 15; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R9", "idle up_idx", up_idx, sv_up);
    chk("R9", "idle b_up", b_up, sv_bu);
    chk("R9", "idle converged", converged, sv_conv);
    box_c = ONE; tol = 262;
    for (int i = 0; i < 10; i++) set_s(i, HALF, i % 2, (i * 3 - 7) * 1000);
    ref_model(10);
    run_pass(10, 0, 1);
    check_out("R3", "R5");
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    num_samples = '0;
    box_c = ONE;
    tol = 262;
    for (int i = 0; i < MAXS; i++) set_s(i, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_hand();
    t_pattern();
    t_ties();
    t_empty();
    t_overflow();
    t_zero();
    t_tol_edge();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule